// File: doc/BRIEF.md
# SPI Serial Memory Command Engine

This block is the serial-side command engine of a byte-wide non-volatile memory model. It acts as an SPI slave in clock mode 0 or 3. It runs on the system clock and oversamples the serial pins through synchronizers, so chip select, serial clock and serial data are treated as ordinary inputs. It decodes a one-byte instruction and then runs an array read, a page write, a status read or write, or a set or clear of the write-enable latch. Every field moves most significant bit first. Input bits are captured on the serial clock rising edge, and the output bit changes after the falling edge.

The block owns the address pointer, a one-page write buffer that records which bytes it holds, and the decision taken when chip select rises. When a write sequence ends cleanly and the write-enable latch is set, the block raises a request to an outside protection and timing controller and holds it. A granted array write copies the buffered bytes of the addressed page into the array. A granted status write loads the protection fields. A refusal changes nothing. The controller also drives a busy input that appears as the write-in-progress status bit and blocks array reads.

The array is 2^MEM_AW bytes with pages of PAGE_B bytes. The address field on the wire is 16 bits wide, and only its low MEM_AW bits are used.

Top module: `pm_cmd_engine`

## Requirements
- R1: After reset the output enable is low, and chip select must be seen high and then low before a command is decoded. Bits clocked while chip select has stayed low since reset are ignored.
- R2: Instruction 03h followed by a 16-bit address returns bytes from consecutive addresses. Address bits above MEM_AW are ignored, and the pointer steps from 2^MEM_AW-1 to 0.
- R3: spi_so_oe is high only while selected and in the data phase of a read or status read, and it goes low once chip select rises.
- R4: Instruction 06h sets the write-enable latch (status bit 1) and 04h clears it. Either takes effect only if chip select rises after exactly 8 bits.
- R5: Instruction 02h raises a commit request only when chip select rises on a byte boundary after at least one data byte and the latch is set. Otherwise no request is made, the array is unchanged and the latch keeps its value.
- R6: Write data bytes land at successive offsets of the addressed page. An offset past the page end wraps to the page start and overwrites it, and bytes that were not sent keep their old contents.
- R7: req_valid, req_status (0 array, 1 status) and req_page are held until rsp_valid. With rsp_ok=1 the write is applied and the latch cleared. With rsp_ok=0 nothing changes and the latch stays set.
- R8: Instruction 05h returns the status byte {WPEN bit 7, 0 in bits 6:4, BP bits 3:2, latch bit 1, WIP bit 0} repeatedly while clocks continue. WIP is high while cyc_busy is high.
- R9: Instruction 01h with one data byte and a chip-select rise on that byte boundary requests a status write. On grant, BP takes data bits 3:2 and WPEN takes bit 7, and both appear on stat_bp and stat_wpen.
- R10: An instruction 03h received while cyc_busy is high is ignored, and the output is not enabled.
- R11: An unknown instruction is ignored until chip select rises. Later bytes in the same selection are not decoded, and neither the output enable nor the status changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_si | input | 1 | Serial data into the block |
| spi_so | output | 1 | Serial data out of the block |
| spi_so_oe | output | 1 | Output enable for spi_so |
| cyc_busy | input | 1 | Internal write cycle in progress, from the controller |
| req_valid | output | 1 | Commit request pending |
| req_status | output | 1 | Request targets the status register (1) or the array (0) |
| req_page | output | MEM_AW-log2(PAGE_B) | Page index of an array request |
| stat_bp | output | 2 | Current block-protect field |
| stat_wpen | output | 1 | Current write-protect-enable bit |
| rsp_valid | input | 1 | Controller answer strobe |
| rsp_ok | input | 1 | Controller grants the request |

## Verification
The hardest case to reach from the ports is a chip-select rise that falls a few bits after a data byte boundary. The write has then buffered good data and the latch is set, yet no commit may follow. The bench adds a partial byte of single serial clock pulses after a full data byte before it deselects. It then confirms at the ports that the controller saw no request, that the array location still holds its earlier pattern, and that the latch is still set. The page-wrap case is reached the same way: a full page is filled first, so that both the overwritten bytes and the untouched bytes have known values.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WLOCK = 8'h04;
  localparam logic [7:0] OP_WOPEN = 8'h06;
  localparam logic [7:0] OP_SRGET = 8'h05;
  localparam logic [7:0] OP_SRPUT = 8'h01;

  typedef enum logic [3:0] {
    S_OFF, S_IDLE, S_CMD, S_ADH, S_ADL, S_RDATA, S_WDATA,
    S_SRGET, S_SRPUT, S_SRDONE, S_OPDONE, S_IGN, S_REQ, S_DRAIN
  } eng_state_t;
endpackage

// File: rtl/pm_spi_front.sv
module pm_spi_front #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_pin,
  input  logic sck_pin,
  input  logic si_pin,
  output logic rst_n_s,
  output logic cs_sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic si_s
);
  logic [1:0] rs_q;
  logic [2:0] chain_q [STAGES];
  logic       sck_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_s) begin
          if (!rst_n_s) chain_q[0] <= 3'b000;
          else          chain_q[0] <= {cs_n_pin, sck_pin, si_pin};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_s) begin
          if (!rst_n_s) chain_q[g] <= 3'b000;
          else          chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) sck_prev_q <= 1'b0;
    else          sck_prev_q <= chain_q[STAGES-1][1];
  end

  assign cs_sel   = ~chain_q[STAGES-1][2];
  assign si_s     = chain_q[STAGES-1][0];
  assign sck_rise = chain_q[STAGES-1][1] & ~sck_prev_q;
  assign sck_fall = ~chain_q[STAGES-1][1] & sck_prev_q;
endmodule

// File: rtl/pm_page_buf.sv
module pm_page_buf #(
  parameter int PAGE_B  = 64,
  parameter int PAGE_AW = $clog2(PAGE_B)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [PAGE_AW-1:0] wr_idx,
  input  logic [7:0]         wr_data,
  input  logic [PAGE_AW-1:0] rd_idx,
  output logic [7:0]         rd_data,
  output logic               rd_valid
);
  logic [PAGE_B-1:0] vld_q;
  logic [7:0]        dat_q [PAGE_B];

  generate
    for (genvar g = 0; g < PAGE_B; g++) begin : g_lane
      logic hit;
      assign hit = wr_en && (wr_idx == PAGE_AW'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   vld_q[g] <= 1'b0;
        else if (clr) vld_q[g] <= 1'b0;
        else if (hit) vld_q[g] <= 1'b1;
      end
      always_ff @(posedge clk) begin
        if (hit) dat_q[g] <= wr_data;
      end
    end
  endgenerate

  assign rd_data  = dat_q[rd_idx];
  assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/pm_array.sv
module pm_array #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end
  assign rdata = mem[raddr];
endmodule

// File: rtl/pm_cmd_engine.sv
module pm_cmd_engine
  import pm_pkg::*;
#(
  parameter int MEM_AW = 10,
  parameter int PAGE_B = 64
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 spi_cs_n,
  input  logic                                 spi_sck,
  input  logic                                 spi_si,
  output logic                                 spi_so,
  output logic                                 spi_so_oe,
  input  logic                                 cyc_busy,
  output logic                                 req_valid,
  output logic                                 req_status,
  output logic [MEM_AW-$clog2(PAGE_B)-1:0]     req_page,
  output logic [1:0]                           stat_bp,
  output logic                                 stat_wpen,
  input  logic                                 rsp_valid,
  input  logic                                 rsp_ok
);
  localparam int PAGE_AW = $clog2(PAGE_B);
  localparam int PG_W    = MEM_AW - PAGE_AW;
  localparam int HI_W    = MEM_AW - 8;

  logic rst_s, cs_sel, sck_rise, sck_fall, si_s;

  pm_spi_front #(.STAGES(2)) u_front (
    .clk(clk), .rst_n(rst_n), .cs_n_pin(spi_cs_n), .sck_pin(spi_sck),
    .si_pin(spi_si), .rst_n_s(rst_s), .cs_sel(cs_sel),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .si_s(si_s)
  );

  eng_state_t        state_q, state_d;
  logic [2:0]        bit_q, bit_d;
  logic [6:0]        rx_q, rx_d;
  logic [HI_W-1:0]   ahi_q, ahi_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [7:0]        tx_q, tx_d;
  logic              wel_q, wel_d;
  logic [1:0]        bp_q, bp_d, nbp_q, nbp_d;
  logic              wpen_q, wpen_d, nwpen_q, nwpen_d;
  logic              got_q, got_d;
  logic              rdm_q, rdm_d;
  logic              opset_q, opset_d;
  logic              rqs_q, rqs_d;
  logic              oe_q, oe_d;
  logic [PAGE_AW-1:0] drn_q, drn_d;

  logic [7:0] byte_in, status_byte, arr_rdata, buf_rdata;
  logic       byte_done, wip, drain_act, buf_clr, buf_we, buf_vld, arr_we;

  assign byte_in     = {rx_q, si_s};
  assign byte_done   = sck_rise && (bit_q == 3'd7);
  assign drain_act   = (state_q == S_DRAIN);
  assign wip         = cyc_busy || (state_q == S_REQ) || drain_act;
  assign status_byte = {wpen_q, 3'b000, bp_q, wel_q, wip};

  pm_page_buf #(.PAGE_B(PAGE_B), .PAGE_AW(PAGE_AW)) u_buf (
    .clk(clk), .rst_n(rst_s), .clr(buf_clr), .wr_en(buf_we),
    .wr_idx(addr_q[PAGE_AW-1:0]), .wr_data(byte_in),
    .rd_idx(drn_q), .rd_data(buf_rdata), .rd_valid(buf_vld)
  );

  assign arr_we = drain_act && buf_vld;

  pm_array #(.AW(MEM_AW)) u_arr (
    .clk(clk), .we(arr_we), .waddr({addr_q[MEM_AW-1:PAGE_AW], drn_q}),
    .wdata(buf_rdata), .raddr(addr_q), .rdata(arr_rdata)
  );

  always_comb begin
    state_d = state_q; bit_d = bit_q; rx_d = rx_q; ahi_d = ahi_q;
    addr_d = addr_q; tx_d = tx_q; wel_d = wel_q; bp_d = bp_q;
    wpen_d = wpen_q; nbp_d = nbp_q; nwpen_d = nwpen_q; got_d = got_q;
    rdm_d = rdm_q; opset_d = opset_q; rqs_d = rqs_q; drn_d = drn_q;
    buf_clr = 1'b0; buf_we = 1'b0;

    if (sck_rise && cs_sel) begin
      rx_d  = byte_in[6:0];
      bit_d = bit_q + 3'd1;
    end

    unique case (state_q)
      S_OFF:  if (!cs_sel) state_d = S_IDLE;
      S_IDLE: begin
        bit_d = 3'd0;
        if (cs_sel) state_d = S_CMD;
      end
      S_CMD: begin
        if (!cs_sel) state_d = S_IDLE;
        else if (byte_done) begin
          unique case (byte_in)
            OP_READ:  begin state_d = cyc_busy ? S_IGN : S_ADH; rdm_d = 1'b1; end
            OP_WRITE: begin state_d = S_ADH; rdm_d = 1'b0; end
            OP_WOPEN: begin state_d = S_OPDONE; opset_d = 1'b1; end
            OP_WLOCK: begin state_d = S_OPDONE; opset_d = 1'b0; end
            OP_SRGET: state_d = S_SRGET;
            OP_SRPUT: state_d = S_SRPUT;
            default:  state_d = S_IGN;
          endcase
        end
      end
      S_ADH: begin
        if (!cs_sel) state_d = S_IDLE;
        else if (byte_done) begin
          ahi_d   = byte_in[HI_W-1:0];
          state_d = S_ADL;
        end
      end
      S_ADL: begin
        if (!cs_sel) state_d = S_IDLE;
        else if (byte_done) begin
          addr_d  = {ahi_q, byte_in};
          state_d = rdm_q ? S_RDATA : S_WDATA;
          buf_clr = ~rdm_q;
          got_d   = 1'b0;
        end
      end
      S_RDATA: begin
        if (!cs_sel) state_d = S_IDLE;
        else if (byte_done) addr_d = addr_q + MEM_AW'(1);
      end
      S_WDATA: begin
        if (!cs_sel) begin
          if ((bit_q == 3'd0) && got_q && wel_q) begin
            state_d = S_REQ;
            rqs_d   = 1'b0;
          end else state_d = S_IDLE;
        end else if (byte_done) begin
          buf_we = 1'b1;
          got_d  = 1'b1;
          addr_d = {addr_q[MEM_AW-1:PAGE_AW], addr_q[PAGE_AW-1:0] + PAGE_AW'(1)};
        end
      end
      S_SRGET: if (!cs_sel) state_d = S_IDLE;
      S_SRPUT: begin
        if (!cs_sel) state_d = S_IDLE;
        else if (byte_done) begin
          nbp_d   = byte_in[3:2];
          nwpen_d = byte_in[7];
          state_d = S_SRDONE;
        end
      end
      S_SRDONE: begin
        if (!cs_sel) begin
          state_d = wel_q ? S_REQ : S_IDLE;
          rqs_d   = 1'b1;
        end else if (sck_rise) state_d = S_IGN;
      end
      S_OPDONE: begin
        if (!cs_sel) begin
          wel_d   = opset_q;
          state_d = S_IDLE;
        end else if (sck_rise) state_d = S_IGN;
      end
      S_IGN: if (!cs_sel) state_d = S_IDLE;
      S_REQ: begin
        if (rsp_valid) begin
          if (!rsp_ok) state_d = S_OFF;
          else if (rqs_q) begin
            bp_d    = nbp_q;
            wpen_d  = nwpen_q;
            wel_d   = 1'b0;
            state_d = S_OFF;
          end else begin
            drn_d   = '0;
            state_d = S_DRAIN;
          end
        end
      end
      S_DRAIN: begin
        drn_d = drn_q + PAGE_AW'(1);
        if (drn_q == PAGE_AW'(PAGE_B - 1)) begin
          wel_d   = 1'b0;
          state_d = S_OFF;
        end
      end
      default: state_d = S_OFF;
    endcase

    if (sck_fall && cs_sel && ((state_q == S_RDATA) || (state_q == S_SRGET))) begin
      if (bit_q == 3'd0) tx_d = (state_q == S_RDATA) ? arr_rdata : status_byte;
      else               tx_d = {tx_q[6:0], 1'b0};
    end

    oe_d = cs_sel && ((state_q == S_RDATA) || (state_q == S_SRGET));
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= S_OFF;
      bit_q   <= 3'd0;
      wel_q   <= 1'b0;
      bp_q    <= 2'b00;
      wpen_q  <= 1'b0;
      got_q   <= 1'b0;
      rdm_q   <= 1'b0;
      opset_q <= 1'b0;
      rqs_q   <= 1'b0;
      oe_q    <= 1'b0;
      drn_q   <= '0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      wpen_q  <= wpen_d;
      got_q   <= got_d;
      rdm_q   <= rdm_d;
      opset_q <= opset_d;
      rqs_q   <= rqs_d;
      oe_q    <= oe_d;
      drn_q   <= drn_d;
    end
  end

  always_ff @(posedge clk) begin
    rx_q    <= rx_d;
    ahi_q   <= ahi_d;
    addr_q  <= addr_d;
    nbp_q   <= nbp_d;
    nwpen_q <= nwpen_d;
    if (sck_fall) tx_q <= tx_d;
  end

  assign spi_so     = tx_q[7];
  assign spi_so_oe  = oe_q;
  assign req_valid  = (state_q == S_REQ);
  assign req_status = rqs_q;
  assign req_page   = addr_q[MEM_AW-1:PAGE_AW];
  assign stat_bp    = bp_q;
  assign stat_wpen  = wpen_q;
endmodule

// File: rtl/pm_cmd_engine_chk.sv
module pm_cmd_engine_chk #(
  parameter int PG_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_sel,
  input logic            so_oe,
  input logic            req_valid,
  input logic            req_status,
  input logic [PG_W-1:0] req_page,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic            wel,
  input logic            drain_act
);
  AST_OE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> $past(cs_sel)); // R3

  AST_NO_OE_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid || drain_act) |-> !so_oe); // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_page) && $stable(req_status))); // R7

  AST_DRAIN_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drain_act) |-> $past(req_valid && rsp_valid && rsp_ok && !req_status)); // R7

  AST_WEL_SET_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> !$past(cs_sel)); // R4

  AST_WEL_CLEAR_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drain_act) |-> !wel); // R5
endmodule

bind pm_cmd_engine pm_cmd_engine_chk #(.PG_W(PG_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .cs_sel(cs_sel), .so_oe(spi_so_oe),
  .req_valid(req_valid), .req_status(req_status), .req_page(req_page),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .wel(wel_q), .drain_act(drain_act)
);

// File: tb/sim_pm_cmd_engine.sv
module sim_pm_cmd_engine;
  localparam int CLK_P  = 10;
  localparam int HALF   = 8;
  localparam int MEM_AW = 10;

  logic clk = 1'b0;
  logic rst_n, spi_cs_n, spi_sck, spi_si, cyc_busy, rsp_valid, rsp_ok;
  logic spi_so, spi_so_oe, req_valid, req_status, stat_wpen;
  logic [3:0] req_page;
  logic [1:0] stat_bp;

  int n_tests = 0, n_fail = 0, req_cnt = 0;
  logic grant_ok = 1'b1, last_status = 1'b0, oe_seen = 1'b0;
  logic [3:0] last_page = '0;
  logic [7:0] wbuf [64];
  logic [7:0] rbuf [8];

  always #(CLK_P/2) clk = ~clk;

  pm_cmd_engine #(.MEM_AW(MEM_AW), .PAGE_B(64)) u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .cyc_busy(cyc_busy), .req_valid(req_valid), .req_status(req_status),
    .req_page(req_page), .stat_bp(stat_bp), .stat_wpen(stat_wpen),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    rsp_valid = 1'b0; rsp_ok = 1'b0;
    forever begin
      @(negedge clk);
      if (req_valid === 1'b1) begin
        req_cnt++;
        last_status = req_status;
        last_page   = req_page;
        @(negedge clk);
        rsp_ok = grant_ok; rsp_valid = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (spi_so_oe === 1'b1) oe_seen = 1'b1;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic spi_bit(input logic b, output logic r);
    spi_si = b;
    repeat (HALF) @(negedge clk);
    r = spi_so;
    spi_sck = 1'b1;
    repeat (HALF) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      spi_bit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic cmd8(input logic [7:0] op);
    logic [7:0] d;
    sel(); xfer(op, d); desel();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic write_n(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    desel();
    repeat (100) @(negedge clk);
  endtask

  task automatic read_n(input logic [15:0] a, input int n);
    logic [7:0] d;
    sel(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
    desel();
  endtask

  task automatic t_reset();
    logic [7:0] d, s;
    check("R1 oe after reset", {15'd0, spi_so_oe}, 16'd0);
    xfer(8'h06, d);
    spi_cs_n = 1'b1;
    repeat (10) @(negedge clk);
    rdsr(s);
    check("R1 no command before first select", {8'd0, s}, 16'h0000);
  endtask

  task automatic t_latch();
    logic [7:0] s, d;
    logic r;
    cmd8(8'h06); rdsr(s);
    check("R4 set latch", {8'd0, s}, 16'h0002);
    cmd8(8'h04); rdsr(s);
    check("R4 clear latch", {8'd0, s}, 16'h0000);
    sel(); xfer(8'h06, d); spi_bit(1'b0, r); desel(); rdsr(s);
    check("R4 nine bits ignored", {8'd0, s}, 16'h0000);
  endtask

  task automatic t_status_repeat();
    logic [7:0] d, a, b;
    cmd8(8'h06);
    oe_seen = 1'b0;
    sel(); xfer(8'h05, d); xfer(8'h00, a); xfer(8'h00, b); desel();
    check("R8 first status", {8'd0, a}, 16'h0002);
    check("R8 repeated status", {8'd0, b}, 16'h0002);
    check("R3 oe during status", {15'd0, oe_seen}, 16'd1);
    check("R3 oe after deselect", {15'd0, spi_so_oe}, 16'd0);
    cmd8(8'h04);
  endtask

  task automatic t_write_basic();
    logic [7:0] s;
    int c;
    c = req_cnt;
    cmd8(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    write_n(16'h0000, 3);
    check("R7 one array request", 16'(req_cnt - c), 16'd1);
    check("R7 array kind", {15'd0, last_status}, 16'd0);
    read_n(16'h0000, 3);
    check("R2 seq byte0", {8'd0, rbuf[0]}, 16'h0011);
    check("R2 seq byte1", {8'd0, rbuf[1]}, 16'h0022);
    check("R2 seq byte2", {8'd0, rbuf[2]}, 16'h0033);
    rdsr(s);
    check("R7 latch cleared after grant", {8'd0, s}, 16'h0000);
  endtask

  task automatic t_page_wrap();
    for (int i = 0; i < 64; i++) wbuf[i] = 8'(8'h80 + i);
    cmd8(8'h06); write_n(16'h0040, 64);
    check("R7 page index", {12'd0, last_page}, 16'd1);
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3; wbuf[3] = 8'hD4;
    cmd8(8'h06); write_n(16'h007E, 4);
    read_n(16'h007E, 2);
    check("R6 byte at offset 62", {8'd0, rbuf[0]}, 16'h00A1);
    check("R6 byte at offset 63", {8'd0, rbuf[1]}, 16'h00B2);
    read_n(16'h0040, 3);
    check("R6 wrapped to offset 0", {8'd0, rbuf[0]}, 16'h00C3);
    check("R6 wrapped to offset 1", {8'd0, rbuf[1]}, 16'h00D4);
    check("R6 untouched offset 2", {8'd0, rbuf[2]}, 16'h0082);
  endtask

  task automatic t_abort();
    logic [7:0] d, s;
    logic r;
    int c;
    c = req_cnt;
    cmd8(8'h06);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h50, d); xfer(8'h5A, d);
    spi_bit(1'b0, r); spi_bit(1'b1, r); spi_bit(1'b0, r);
    desel(); repeat (100) @(negedge clk);
    check("R5 mid-byte rise no request", 16'(req_cnt - c), 16'd0);
    read_n(16'h0050, 1);
    check("R5 array unchanged", {8'd0, rbuf[0]}, 16'h0090);
    rdsr(s);
    check("R5 latch kept", {8'd0, s}, 16'h0002);
    sel(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h51, d); desel();
    repeat (100) @(negedge clk);
    check("R5 no data byte no request", 16'(req_cnt - c), 16'd0);
    cmd8(8'h04);
    wbuf[0] = 8'h00; write_n(16'h0051, 1);
    check("R5 latch clear no request", 16'(req_cnt - c), 16'd0);
    read_n(16'h0051, 1);
    check("R5 array unchanged without latch", {8'd0, rbuf[0]}, 16'h0091);
  endtask

  task automatic t_deny();
    logic [7:0] s;
    int c;
    c = req_cnt;
    grant_ok = 1'b0;
    cmd8(8'h06);
    wbuf[0] = 8'hEE; write_n(16'h0045, 1);
    check("R7 refused request seen", 16'(req_cnt - c), 16'd1);
    read_n(16'h0045, 1);
    check("R7 refused leaves array", {8'd0, rbuf[0]}, 16'h0085);
    rdsr(s);
    check("R7 refused keeps latch", {8'd0, s}, 16'h0002);
    grant_ok = 1'b1;
    cmd8(8'h04);
  endtask

  task automatic t_rollover();
    cmd8(8'h06);
    wbuf[0] = 8'h77; wbuf[1] = 8'h88;
    write_n(16'h03FE, 2);
    read_n(16'hFFFE, 3);
    check("R2 upper bits ignored", {8'd0, rbuf[0]}, 16'h0077);
    check("R2 top address", {8'd0, rbuf[1]}, 16'h0088);
    check("R2 roll to zero", {8'd0, rbuf[2]}, 16'h0011);
  endtask

  task automatic t_wrsr();
    logic [7:0] d, s;
    cmd8(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h8C, d); desel();
    repeat (20) @(negedge clk);
    check("R9 status request kind", {15'd0, last_status}, 16'd1);
    rdsr(s);
    check("R9 status after grant", {8'd0, s}, 16'h008C);
    check("R9 bp port", {14'd0, stat_bp}, 16'd3);
    check("R9 wpen port", {15'd0, stat_wpen}, 16'd1);
    cmd8(8'h06);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_busy();
    logic [7:0] s;
    cyc_busy = 1'b1;
    rdsr(s);
    check("R8 busy shows wip", {8'd0, s}, 16'h0001);
    oe_seen = 1'b0;
    read_n(16'h0000, 2);
    check("R10 read ignored while busy", {15'd0, oe_seen}, 16'd0);
    cyc_busy = 1'b0;
  endtask

  task automatic t_unknown();
    logic [7:0] d, s;
    cmd8(8'h06);
    oe_seen = 1'b0;
    sel(); xfer(8'hFF, d); xfer(8'h05, d); xfer(8'h00, d); desel();
    check("R11 no output after unknown", {15'd0, oe_seen}, 16'd0);
    rdsr(s);
    check("R11 status untouched", {8'd0, s}, 16'h0002);
    sel(); xfer(8'hAB, d); xfer(8'h04, d); desel();
    rdsr(s);
    check("R11 later byte not decoded", {8'd0, s}, 16'h0002);
    cmd8(8'h04);
  endtask

  initial begin
    rst_n = 1'b0; spi_cs_n = 1'b0; spi_sck = 1'b0; spi_si = 1'b0;
    cyc_busy = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_status_repeat();
    t_write_basic();
    t_page_wrap();
    t_abort();
    t_deny();
    t_rollover();
    t_wrsr();
    t_busy();
    t_unknown();
    summary();
  end
endmodule